// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node side of a directory-based coherence scheme for a small shared-memory system with a fixed number of nodes. For every memory block the home owns, it keeps a directory entry and a data word. Each entry holds a coherence state and a bit vector with one bit per node. The block never broadcasts. Invalidations and fetches go only to the nodes whose bits are set in the entry.

Requesting nodes send read-miss, write-miss and writeback messages on a valid/ready request port. The controller serves one request at a time and drops `req_ready` while a request is in flight. It sends data replies, invalidates and fetches on a valid/ready message port. When it fetches from an owner, the owner's data comes back on a response port. Messages are assumed to be delivered in the order they were sent, so invalidations are not acknowledged. A requester stays blocked until its data reply arrives.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset the controller idles with `req_ready` high, `msg_valid` low and `rsp_ready` low. Every entry is Uncached with an empty bit vector, and every data word is zero.
- R2: A read miss (request kind 0) to an Uncached or Shared block sends exactly one message, a data reply (message kind 0) to the requester carrying the memory word. The entry becomes Shared with the requester's bit added.
- R3: A write miss (request kind 1) to an Uncached block sends only a data reply to the requester. The entry becomes Exclusive with only the requester's bit set.
- R4: A write miss to a Shared block sends one invalidate (message kind 1) to each sharer except the requester, in ascending node order, before the data reply. The entry then becomes Exclusive to the requester.
- R5: A read miss to an Exclusive block sends a fetch (message kind 2) to the owner, writes the returned word into memory and replies with it. The entry is left Shared with the owner's and the requester's bits set.
- R6: A write miss to an Exclusive block fetches from the owner, replies with the fetched word and makes the requester the only holder in the Exclusive state.
- R7: A writeback (request kind 2) from the recorded owner of an Exclusive block stores its data in memory, makes the entry Uncached with an empty vector, and sends no message.
- R8: A writeback from a node that is not the owner, or to a block that is not Exclusive, is ignored. No message is sent and the memory word is left unchanged.
- R9: Once a request is accepted, `req_ready` stays low until that transaction's last message has been accepted.
- R10: While `msg_valid` is high and `msg_ready` is low, the message kind, destination, address and data hold steady.
- R11: Every message names the address of the request it serves.
- R12: `rsp_ready` is high only while the controller waits for fetched data. No reply is sent before that data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_src | input | IDW | Requesting node |
| req_addr | input | AW | Block index |
| req_data | input | DW | Writeback data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch |
| msg_dst | output | IDW | Destination node |
| msg_addr | output | AW | Block index of the message |
| msg_data | output | DW | Reply data (zero for other kinds) |
| rsp_valid | input | 1 | Fetched data present |
| rsp_ready | output | 1 | Controller waits for fetched data |
| rsp_data | input | DW | Data returned by the owner |

## Verification
The hardest situation to reach from the ports is a write miss to a block with several sharers, where each invalidate has to wait under back-pressure while the same message stays on the port. The bench reaches it by first sending three read misses from different nodes to one block. It then issues a write miss from a fourth node while toggling `msg_ready` every cycle. A second hard case is an owner that answers a fetch late. The bench holds the fetched data back for several cycles and checks that no reply leaves early.

// File: rtl/dir_home_pkg.sv
// Shared encodings for the home directory controller.
// Assumes: request, message and state codes are 2 bits wide on every port.
package dir_home_pkg;
    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_INVAL = 2'd1,
        MS_FETCH = 2'd2
    } msg_kind_e;

    typedef enum logic [1:0] {
        DS_UNCACHED = 2'd0,
        DS_SHARED   = 2'd1,
        DS_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DECIDE,
        PH_INVAL,
        PH_FETCH,
        PH_WAIT,
        PH_REPLY
    } phase_e;
endpackage

// File: rtl/dir_entry_store.sv
// Directory entry file: one state code and one holder vector per block.
// Assumes: a single write port and an asynchronous read port; a reset clears
// every entry to Uncached with no holders.
module dir_entry_store #(
    parameter int NODES = 4,
    parameter int NBLK  = 8,
    localparam int AW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic [1:0]       rd_state,
    output logic [NODES-1:0] rd_holders,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [1:0]       wr_state,
    input  logic [NODES-1:0] wr_holders
);
    import dir_home_pkg::*;

    logic [NBLK-1:0][1:0]       st_all;
    logic [NBLK-1:0][NODES-1:0] hv_all;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [1:0]       st_q;
        logic [NODES-1:0] hv_q;

        // Update this block's entry when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= DS_UNCACHED;
                hv_q <= '0;
            end else if (wr_en && wr_addr == AW'(b)) begin
                st_q <= wr_state;
                hv_q <= wr_holders;
            end
        end

        assign st_all[b] = st_q;
        assign hv_all[b] = hv_q;
    end

    assign rd_state   = st_all[rd_addr];
    assign rd_holders = hv_all[rd_addr];
endmodule

// File: rtl/dir_data_store.sv
// Home memory words, one per block, held in registers.
// Assumes: one write port, an asynchronous read port, and zero after reset.
module dir_data_store #(
    parameter int NBLK = 8,
    parameter int DW   = 16,
    localparam int AW  = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [NBLK-1:0][DW-1:0] word_all;

    for (genvar b = 0; b < NBLK; b++) begin : g_word
        logic [DW-1:0] word_q;

        // Store a new word when the write port selects this block.
        always_ff @(posedge clk) begin
            if (!rst_n)                            word_q <= '0;
            else if (wr_en && wr_addr == AW'(b))   word_q <= wr_data;
        end

        assign word_all[b] = word_q;
    end

    assign rd_data = word_all[rd_addr];
endmodule

// File: rtl/dir_lowest_node.sv
// Picks the lowest-numbered node whose bit is set in a holder vector.
// Assumes: purely combinational; idx is zero when no bit is set.
module dir_lowest_node #(
    parameter int NODES = 4,
    localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic [NODES-1:0] mask,
    output logic [IDW-1:0]   idx,
    output logic             any
);
    // Scan from the top so that the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IDW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node directory controller. It takes one coherence request at a time,
// sends invalidates or a fetch only to the recorded holders, then replies
// with data and commits the new directory entry.
// Assumes: messages are delivered in order, so invalidates are not
// acknowledged; the owner answers every fetch on the response port.
module dir_home_ctrl #(
    parameter int NODES = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int AW   = $clog2(NBLK)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [1:0]     req_kind,
    input  logic [IDW-1:0] req_src,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    output logic           msg_valid,
    input  logic           msg_ready,
    output logic [1:0]     msg_kind,
    output logic [IDW-1:0] msg_dst,
    output logic [AW-1:0]  msg_addr,
    output logic [DW-1:0]  msg_data,
    input  logic           rsp_valid,
    output logic           rsp_ready,
    input  logic [DW-1:0]  rsp_data
);
    import dir_home_pkg::*;

    localparam logic [NODES-1:0] ONE = NODES'(1);

    phase_e           phase_q;
    logic [1:0]       kind_q;
    logic [IDW-1:0]   src_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    data_q;
    logic [1:0]       cur_st_q;
    logic [NODES-1:0] cur_hv_q;
    logic [NODES-1:0] pend_q;
    logic [1:0]       new_st_q;
    logic [NODES-1:0] new_hv_q;

    logic [AW-1:0]    look_addr;
    logic [1:0]       ent_st;
    logic [NODES-1:0] ent_hv;
    logic [DW-1:0]    mem_word;
    logic             ent_we;
    logic [1:0]       ent_wst;
    logic [NODES-1:0] ent_whv;
    logic             mem_we;
    logic [DW-1:0]    mem_wdata;
    logic [IDW-1:0]   pick_idx;
    logic             pick_any;
    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] pick_bit;
    logic             wb_ok;

    assign look_addr = (phase_q == PH_IDLE) ? req_addr : addr_q;
    assign src_bit   = ONE << src_q;
    assign pick_bit  = ONE << pick_idx;
    assign wb_ok     = (kind_q == RQ_WBACK) && (cur_st_q == DS_EXCL) && cur_hv_q[src_q];

    dir_entry_store #(.NODES(NODES), .NBLK(NBLK)) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (look_addr),
        .rd_state   (ent_st),
        .rd_holders (ent_hv),
        .wr_en      (ent_we),
        .wr_addr    (addr_q),
        .wr_state   (ent_wst),
        .wr_holders (ent_whv)
    );

    dir_data_store #(.NBLK(NBLK), .DW(DW)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (look_addr),
        .rd_data (mem_word),
        .wr_en   (mem_we),
        .wr_addr (addr_q),
        .wr_data (mem_wdata)
    );

    dir_lowest_node #(.NODES(NODES)) u_pick (
        .mask (pend_q),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    // Commit the directory entry on an accepted owner writeback or at the reply.
    always_comb begin
        ent_we  = 1'b0;
        ent_wst = new_st_q;
        ent_whv = new_hv_q;
        if (phase_q == PH_DECIDE && wb_ok) begin
            ent_we  = 1'b1;
            ent_wst = DS_UNCACHED;
            ent_whv = '0;
        end else if (phase_q == PH_REPLY && msg_ready) begin
            ent_we  = 1'b1;
        end
    end

    // Update memory from an owner writeback or from data returned by a fetch.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = rsp_data;
        if (phase_q == PH_DECIDE && wb_ok) begin
            mem_we    = 1'b1;
            mem_wdata = wdata_q;
        end else if (phase_q == PH_WAIT && rsp_valid) begin
            mem_we    = 1'b1;
        end
    end

    // Drive the outgoing message from the current phase.
    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MS_DATA;
        msg_dst   = pick_idx;
        msg_addr  = addr_q;
        msg_data  = '0;
        case (phase_q)
            PH_INVAL: begin
                msg_valid = pick_any;
                msg_kind  = MS_INVAL;
            end
            PH_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = MS_FETCH;
            end
            PH_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = MS_DATA;
                msg_dst   = src_q;
                msg_data  = data_q;
            end
            default: ;
        endcase
    end

    assign req_ready = (phase_q == PH_IDLE);
    assign rsp_ready = (phase_q == PH_WAIT);

    // Sequence one transaction: capture, decide, invalidate or fetch, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            kind_q   <= RQ_READ;
            src_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            data_q   <= '0;
            cur_st_q <= DS_UNCACHED;
            cur_hv_q <= '0;
            pend_q   <= '0;
            new_st_q <= DS_UNCACHED;
            new_hv_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        kind_q   <= req_kind;
                        src_q    <= req_src;
                        addr_q   <= req_addr;
                        wdata_q  <= req_data;
                        data_q   <= mem_word;
                        cur_st_q <= ent_st;
                        cur_hv_q <= ent_hv;
                        phase_q  <= PH_DECIDE;
                    end
                end
                PH_DECIDE: begin
                    case (kind_q)
                        RQ_READ: begin
                            new_st_q <= DS_SHARED;
                            new_hv_q <= cur_hv_q | src_bit;
                            if (cur_st_q == DS_EXCL) begin
                                pend_q  <= cur_hv_q;
                                phase_q <= PH_FETCH;
                            end else begin
                                phase_q <= PH_REPLY;
                            end
                        end
                        RQ_WRITE: begin
                            new_st_q <= DS_EXCL;
                            new_hv_q <= src_bit;
                            if (cur_st_q == DS_EXCL) begin
                                pend_q  <= cur_hv_q;
                                phase_q <= PH_FETCH;
                            end else if (cur_st_q == DS_SHARED && (cur_hv_q & ~src_bit) != '0) begin
                                pend_q  <= cur_hv_q & ~src_bit;
                                phase_q <= PH_INVAL;
                            end else begin
                                phase_q <= PH_REPLY;
                            end
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
                PH_INVAL: begin
                    if (msg_ready) begin
                        pend_q <= pend_q & ~pick_bit;
                        if ((pend_q & ~pick_bit) == '0) phase_q <= PH_REPLY;
                    end
                end
                PH_FETCH: begin
                    if (msg_ready) phase_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (rsp_valid) begin
                        data_q  <= rsp_data;
                        phase_q <= PH_REPLY;
                    end
                end
                PH_REPLY: begin
                    if (msg_ready) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dir_home_chk.sv
// Protocol checker for the home directory controller, bound to its ports.
// Assumes: it sees only top-level ports and keeps its own copy of the
// accepted requester.
module dir_home_chk #(
    parameter int NODES = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int IDW  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int AW   = $clog2(NBLK)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [1:0]     req_kind,
    input logic [IDW-1:0] req_src,
    input logic [AW-1:0]  req_addr,
    input logic           msg_valid,
    input logic           msg_ready,
    input logic [1:0]     msg_kind,
    input logic [IDW-1:0] msg_dst,
    input logic [AW-1:0]  msg_addr,
    input logic [DW-1:0]  msg_data,
    input logic           rsp_ready
);
    logic [IDW-1:0] who_q;
    logic [AW-1:0]  where_q;

    // Remember the requester and the address of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            who_q   <= '0;
            where_q <= '0;
        end else if (req_valid && req_ready) begin
            who_q   <= req_src;
            where_q <= req_addr;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> req_ready && !msg_valid && !rsp_ready);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dst)
                                    && $stable(msg_addr) && $stable(msg_data));

    // R12
    rsp_wait_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> !msg_valid && !req_ready);

    // R7
    wback_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_kind == 2'd2 |=> !msg_valid ##1 !msg_valid);

    // R4
    inval_not_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind == 2'd1 |-> msg_dst != who_q);

    // R2
    reply_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind == 2'd0 |-> msg_dst == who_q);

    // R11
    msg_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr == where_q);
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .NBLK(NBLK), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_src   (req_src),
    .req_addr  (req_addr),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_kind  (msg_kind),
    .msg_dst   (msg_dst),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .rsp_ready (rsp_ready)
);

// File: tb/tb_dir_home_ctrl.sv
// Bench for the home directory controller: a table of transactions walked by
// one loop, then directed tests for reset, back-pressure and a slow owner.
module tb_dir_home_ctrl;
    localparam int NODES = 4;
    localparam int NBLK  = 8;
    localparam int DW    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dst;
    logic [2:0]  msg_addr;
    logic [15:0] msg_data;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [15:0] rsp_data = '0;

    dir_home_ctrl #(.NODES(NODES), .NBLK(NBLK), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  src;
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [15:0] fdata;
        logic [3:0]  einv;
        logic        efetch;
        logic [1:0]  efdst;
        logic        ereply;
        logic [15:0] edata;
        logic [3:0]  rq;
    } vec_t;

    // Request kinds: 0 read, 1 write, 2 writeback. Block 1 walks the protocol.
    localparam vec_t VECS [14] = '{
        '{2'd0, 2'd0, 3'd1, 16'h0000, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b1, 16'h0000, 4'd1}, // R1 zero memory
        '{2'd0, 2'd2, 3'd1, 16'h0000, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b1, 16'h0000, 4'd2}, // R2 shared read
        '{2'd1, 2'd3, 3'd1, 16'h0000, 16'h0000, 4'h5, 1'b0, 2'd0, 1'b1, 16'h0000, 4'd4}, // R4 inv 0,2
        '{2'd0, 2'd1, 3'd1, 16'h0000, 16'hA5A5, 4'h0, 1'b1, 2'd3, 1'b1, 16'hA5A5, 4'd5}, // R5 fetch 3
        '{2'd0, 2'd0, 3'd1, 16'h0000, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b1, 16'hA5A5, 4'd5}, // R5 memory kept
        '{2'd1, 2'd1, 3'd1, 16'h0000, 16'h0000, 4'h9, 1'b0, 2'd0, 1'b1, 16'hA5A5, 4'd4}, // R4 skip requester
        '{2'd1, 2'd2, 3'd1, 16'h0000, 16'h1234, 4'h0, 1'b1, 2'd1, 1'b1, 16'h1234, 4'd6}, // R6 fetch 1
        '{2'd2, 2'd0, 3'd1, 16'hFFFF, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b0, 16'h0000, 4'd8}, // R8 non-owner
        '{2'd2, 2'd2, 3'd1, 16'hBEEF, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b0, 16'h0000, 4'd7}, // R7 owner wb
        '{2'd0, 2'd3, 3'd1, 16'h0000, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b1, 16'hBEEF, 4'd7}, // R7 uncached
        '{2'd1, 2'd1, 3'd2, 16'h0000, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b1, 16'h0000, 4'd3}, // R3 write uncached
        '{2'd0, 2'd0, 3'd2, 16'h0000, 16'h7777, 4'h0, 1'b1, 2'd1, 1'b1, 16'h7777, 4'd3}, // R3 owner is 1
        '{2'd2, 2'd3, 3'd3, 16'h1111, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b0, 16'h0000, 4'd8}, // R8 not exclusive
        '{2'd0, 2'd3, 3'd3, 16'h0000, 16'h0000, 4'h0, 1'b0, 2'd0, 1'b1, 16'h0000, 4'd8}  // R8 word unchanged
    };

    logic [3:0]  r_inv;
    logic        r_fetch;
    logic [1:0]  r_fdst;
    logic        r_reply;
    logic [15:0] r_data;
    logic [1:0]  r_rdst;
    logic        r_addr_bad;
    logic        r_order_bad;
    logic        r_busy_bad;
    logic        r_stable_bad;
    logic        r_rsp_bad;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Issue one request and collect every message it causes.
    task automatic run_req(input logic [1:0] k, input logic [1:0] s, input logic [2:0] a,
                           input logic [15:0] wd, input logic [15:0] fd,
                           input bit stall, input int rsp_delay);
        bit fin = 0, held = 0, pend = 0, taken = 0;
        int cnt = 0, last = -1;
        logic [1:0] h_kind, h_dst;
        logic [15:0] h_data;
        r_inv = '0; r_fetch = 0; r_fdst = '0; r_reply = 0; r_data = '0; r_rdst = '0;
        r_addr_bad = 0; r_order_bad = 0; r_stable_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = s; req_addr = a; req_data = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 40 && !fin; c++) begin
            if (c > 0) @(negedge clk);
            if (held && (!msg_valid || msg_kind != h_kind || msg_dst != h_dst || msg_data != h_data))
                r_stable_bad = 1;
            if (k != 2'd2 && req_ready) r_busy_bad = 1;
            if (rsp_ready && msg_valid) r_rsp_bad = 1;
            if (taken) begin rsp_valid = 1'b0; pend = 0; taken = 0; end
            msg_ready = stall ? ~msg_ready : 1'b1;
            if (pend) begin
                if (cnt == 0) begin rsp_valid = 1'b1; rsp_data = fd; end
                else cnt--;
            end
            #1;
            held = msg_valid && !msg_ready;
            h_kind = msg_kind; h_dst = msg_dst; h_data = msg_data;
            if (msg_valid && msg_ready) begin
                if (msg_addr != a) r_addr_bad = 1;
                case (msg_kind)
                    2'd1: begin
                        r_inv[msg_dst] = 1'b1;
                        if (int'(msg_dst) <= last) r_order_bad = 1;
                        last = int'(msg_dst);
                    end
                    2'd2: begin r_fetch = 1; r_fdst = msg_dst; pend = 1; cnt = rsp_delay; end
                    default: begin
                        r_reply = 1; r_data = msg_data; r_rdst = msg_dst; fin = 1;
                        if (pend) r_rsp_bad = 1;
                    end
                endcase
            end
            if (rsp_valid && rsp_ready) taken = 1;
            if (k == 2'd2 && c >= 6) fin = 1;
        end
        @(negedge clk);
        msg_ready = 1'b0;
        rsp_valid = 1'b0;
    endtask

    task automatic check_result(input string tag, input logic [1:0] s, input logic [3:0] einv,
                                input logic efetch, input logic [1:0] efdst,
                                input logic ereply, input logic [15:0] edata);
        check(r_inv == einv, tag, "invalidate set", 32'(r_inv), 32'(einv));
        check(!r_order_bad, tag, "invalidate order", 32'(r_order_bad), 32'h0);
        check(r_fetch == efetch && (!efetch || r_fdst == efdst), tag, "fetch target",
              {r_fetch, 2'b0, r_fdst}, {efetch, 2'b0, efdst});
        check(r_reply == ereply, tag, "reply present", 32'(r_reply), 32'(ereply));
        if (ereply) begin
            check(r_data == edata, tag, "reply data", 32'(r_data), 32'(edata));
            check(r_rdst == s, tag, "reply destination", 32'(r_rdst), 32'(s));
        end
        check(!r_addr_bad, "R11", "message address", 32'(r_addr_bad), 32'h0);
    endtask

    initial begin
        r_busy_bad = 0;
        r_rsp_bad  = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs after reset
        check(req_ready && !msg_valid && !rsp_ready, "R1", "idle after reset",
              {req_ready, msg_valid, rsp_ready}, 32'h4);

        foreach (VECS[i]) begin
            run_req(VECS[i].kind, VECS[i].src, VECS[i].addr, VECS[i].wdata, VECS[i].fdata, 0, 0);
            check_result($sformatf("R%0d", VECS[i].rq), VECS[i].src, VECS[i].einv,
                         VECS[i].efetch, VECS[i].efdst, VECS[i].ereply, VECS[i].edata);
        end

        // R10 three sharers, then a write miss under toggling back-pressure
        run_req(2'd0, 2'd0, 3'd4, 16'h0, 16'h0, 0, 0);
        run_req(2'd0, 2'd1, 3'd4, 16'h0, 16'h0, 0, 0);
        run_req(2'd0, 2'd2, 3'd4, 16'h0, 16'h0, 0, 0);
        run_req(2'd1, 2'd3, 3'd4, 16'h0, 16'h0, 1, 0);
        check_result("R10", 2'd3, 4'h7, 1'b0, 2'd0, 1'b1, 16'h0000);
        check(!r_stable_bad, "R10", "held message stable", 32'(r_stable_bad), 32'h0);

        // R12 owner answers the fetch three cycles late
        run_req(2'd1, 2'd0, 3'd4, 16'h0, 16'h4242, 1, 3);
        check_result("R12", 2'd0, 4'h0, 1'b1, 2'd3, 1'b1, 16'h4242);
        check(!r_stable_bad, "R10", "held message stable", 32'(r_stable_bad), 32'h0);

        check(!r_busy_bad, "R9", "busy while serving", 32'(r_busy_bad), 32'h0);
        check(!r_rsp_bad, "R12", "response window", 32'(r_rsp_bad), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule